// File: doc/BRIEF.md
# Switchable-Order Fractional Noise-Shaping Modulator

This block drives the modulus selection of a fractional feedback divider. It takes an 18-bit fraction word and, once per divided-feedback period, produces a small signed integer. The divider adds that integer to its integer ratio, and the long-run mean of the sequence equals the fraction word divided by 2^18. The modulator is a cascade of first-order accumulators. Each overflow carry is recombined through difference terms, so the quantisation error is pushed towards high offset frequencies.

A run-time select input picks the cascade order. High gives a two-stage cascade with a narrow output span. Low gives a three-stage cascade with steeper noise shaping and a wider span. A dither input adds one bit of weight 2^-19 below the fraction word. The first accumulator's lowest bit then alternates on every update, which breaks up idle tones. The cost is a fixed positive frequency error of one part in 2^19 of the comparison rate.

The state advances only on a single-cycle enable pulse from the divider. A synchronous reset clears all state.

Top module: `mash_dsm`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, every carry delay register and the output. One cycle after reset is released the output reads 0.
- R2: Accumulators, delay registers and the output change only on a clock edge where `step_en` is high. On any other edge the output holds its value.
- R3: The first accumulator is 19 bits wide. Its addend is the fraction word shifted up by one bit, with `dither_en` placed in bit 0. Its carry c1 is the overflow past 2^19. The second stage adds the upper 18 bits of the first stage's new residue. The third stage adds the second stage's new 18-bit residue. Each of these stages carries out past 2^18.
- R4: With `two_stage` high, the value loaded into the output is c1 + c2 − c2', where the primed term is that carry's value at the previous enabled update.
- R5: With `two_stage` low, the value loaded is c1 + c2 − c2' + c3 − 2·c3' + c3''. The doubly primed term is the carry from two enabled updates earlier.
- R6: Dither high makes the first-stage addend odd. The mean output then exceeds the fraction word / 2^18 by exactly 2^-19.
- R7: With a fraction word of 0 and dither low, the output stays 0 on every update.
- R8: The output is a 4-bit two's-complement value. It lies in −1..+2 after a two-stage update and in −3..+4 in all cases.
- R9: The output is registered. A value computed from the inputs present on an enabled edge appears just after that edge.
- R10: An enabled update taken with `two_stage` high forces the third accumulator and both of its carry delays to 0. A later return to three-stage mode therefore starts that stage from a cleared state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | One-cycle pulse per feedback period; advances the modulator |
| frac_k | input | 18 | Fraction word, unsigned |
| two_stage | input | 1 | 1: two-stage cascade, 0: three-stage cascade |
| dither_en | input | 1 | 1: add the half-LSB toggle bit to the first stage |
| offset | output | 4 | Signed divide-ratio offset, two's complement |

## Verification
The bench targets the seams between stages. These include a wrong residue slice passed from the 19-bit first stage to the 18-bit second stage, and a second stage fed the old residue instead of the new one. It also targets a sign or weight error in the −2·c3' term. Any of these makes the per-update sequence drift from a bench model within a few updates. A zero fraction word with dither low must stay at 0, which exposes a stray carry or a dither bit leaking in. The bench toggles the order select mid-run and holds `step_en` low across stretches. A design that left the third stage running in two-stage mode, or that advanced without an enable, would produce values the model rejects. A 1024-update mean check on a quarter-fraction word catches a design whose shaping terms do not cancel over time.

// File: rtl/mash_pkg.sv
package mash_pkg;
   localparam int unsigned MASH_MAX_STAGES = 3;

   typedef enum logic {
      ORDER_THREE = 1'b0,
      ORDER_TWO   = 1'b1
   } mash_order_e;

   function automatic int unsigned stage_width(input int unsigned idx, input int unsigned frac_w);
      return (idx == 0) ? frac_w + 1 : frac_w;
   endfunction
endpackage

// File: rtl/mash_stage.sv
module mash_stage #(
   parameter int unsigned ACC_W = 19,
   parameter int unsigned RES_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             clr,
   input  logic [ACC_W-1:0] addend,
   output logic [RES_W-1:0] residue,
   output logic             carry
);
   localparam int unsigned SUM_W = ACC_W + 1;

   logic [ACC_W-1:0] acc_q;
   logic [SUM_W-1:0] sum;
   logic [ACC_W-1:0] acc_nxt;

   if (RES_W > ACC_W) begin : g_bad_width
      $error("mash_stage: residue wider than accumulator");
   end

   always_comb begin
      sum     = {1'b0, acc_q} + {1'b0, addend};
      acc_nxt = clr ? '0 : sum[ACC_W-1:0];
      carry   = clr ? 1'b0 : sum[ACC_W];
   end

   assign residue = acc_nxt[ACC_W-1 -: RES_W];

   always_ff @(posedge clk) begin
      if (rst)      acc_q <= '0;
      else if (adv) acc_q <= acc_nxt;
   end
endmodule

// File: rtl/mash_shaper.sv
module mash_shaper
   import mash_pkg::*;
#(
   parameter int unsigned STAGES = 3,
   parameter int unsigned OUT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    adv,
   input  logic                    two_stage,
   input  logic [STAGES-1:0]       carry,
   output logic signed [OUT_W-1:0] offset
);
   logic                    c2_d1;
   logic                    c3_d1;
   logic                    c3_d2;
   logic signed [OUT_W-1:0] next_val;
   logic                    third_on;

   if (STAGES != MASH_MAX_STAGES) begin : g_bad_stages
      $error("mash_shaper: exactly three stages are supported");
   end
   if (OUT_W < 4) begin : g_bad_out
      $error("mash_shaper: output needs at least 4 bits");
   end

   assign third_on = (mash_order_e'(two_stage) == ORDER_THREE);

   always_comb begin
      next_val = OUT_W'(carry[0]) + OUT_W'(carry[1]) - OUT_W'(c2_d1);
      if (third_on) begin
         next_val = next_val + OUT_W'(carry[2]) - OUT_W'({c3_d1, 1'b0}) + OUT_W'(c3_d2);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         c2_d1  <= 1'b0;
         c3_d1  <= 1'b0;
         c3_d2  <= 1'b0;
         offset <= '0;
      end else if (adv) begin
         c2_d1  <= carry[1];
         c3_d1  <= third_on ? carry[2] : 1'b0;
         c3_d2  <= third_on ? c3_d1 : 1'b0;
         offset <= next_val;
      end
   end
endmodule

// File: rtl/mash_dsm.sv
module mash_dsm
   import mash_pkg::*;
#(
   parameter int unsigned FRAC_W = 18,
   parameter int unsigned OUT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    step_en,
   input  logic [FRAC_W-1:0]       frac_k,
   input  logic                    two_stage,
   input  logic                    dither_en,
   output logic signed [OUT_W-1:0] offset
);
   localparam int unsigned STAGES = MASH_MAX_STAGES;
   localparam int unsigned ACC0_W = stage_width(0, FRAC_W);

   logic [STAGES-1:0] carry;
   logic [FRAC_W-1:0] res [STAGES];

   if (FRAC_W < 2) begin : g_bad_frac
      $error("mash_dsm: fraction width too small");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      localparam int unsigned SW = stage_width(i, FRAC_W);
      logic [SW-1:0] addend;
      logic          clr;

      if (i == 0) begin : g_first
         assign addend = {frac_k, dither_en};
         assign clr    = 1'b0;
      end else if (i == STAGES - 1) begin : g_last
         assign addend = res[i-1];
         assign clr    = (mash_order_e'(two_stage) == ORDER_TWO);
      end else begin : g_mid
         assign addend = res[i-1];
         assign clr    = 1'b0;
      end

      mash_stage #(
         .ACC_W (SW),
         .RES_W (FRAC_W)
      ) u_stage (
         .clk     (clk),
         .rst     (rst),
         .adv     (step_en),
         .clr     (clr),
         .addend  (addend),
         .residue (res[i]),
         .carry   (carry[i])
      );
   end

   mash_shaper #(
      .STAGES (STAGES),
      .OUT_W  (OUT_W)
   ) u_shaper (
      .clk       (clk),
      .rst       (rst),
      .adv       (step_en),
      .two_stage (two_stage),
      .carry     (carry),
      .offset    (offset)
   );

   if (ACC0_W != FRAC_W + 1) begin : g_bad_acc0
      $error("mash_dsm: first stage width mismatch");
   end
endmodule

// File: rtl/mash_dsm_chk.sv
module mash_dsm_chk #(
   parameter int unsigned OUT_W = 4
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    step_en,
   input logic                    two_stage,
   input logic signed [OUT_W-1:0] offset
);
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> (offset == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(offset));

   p_two_range_r8: assert property (@(posedge clk) disable iff (rst)
      (step_en && two_stage) |=> (offset >= -1 && offset <= 2));

   p_full_range_r8: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (offset >= -3 && offset <= 4));
endmodule

bind mash_dsm mash_dsm_chk #(.OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .step_en   (step_en),
   .two_stage (two_stage),
   .offset    (offset)
);

// File: tb/mash_dsm_test.sv
module mash_dsm_test;
   localparam int CLK_T  = 10;
   localparam int FRAC_W = 18;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              step_en = 1'b0;
   logic [FRAC_W-1:0] frac_k = '0;
   logic              two_stage = 1'b1;
   logic              dither_en = 1'b0;
   logic signed [3:0] offset;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   longint m_a1, m_a2, m_a3;
   int     m_c2d, m_c3d, m_c3dd, m_exp;

   always #(CLK_T/2) clk = ~clk;

   mash_dsm uut (
      .clk       (clk),
      .rst       (rst),
      .step_en   (step_en),
      .frac_k    (frac_k),
      .two_stage (two_stage),
      .dither_en (dither_en),
      .offset    (offset)
   );

   function automatic void model_reset();
      m_a1 = 0; m_a2 = 0; m_a3 = 0;
      m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_exp = 0;
   endfunction

   // R3, R4, R5, R6, R10: reference update for one enabled edge
   function automatic void model_step(input longint k, input bit two, input bit dth);
      longint s1, s2, s3;
      int c1, c2, c3;
      s1 = m_a1 + ((k << 1) | longint'(dth));
      c1 = int'(s1 >> 19);
      m_a1 = s1 & ((64'd1 << 19) - 1);
      s2 = m_a2 + (m_a1 >> 1);
      c2 = int'(s2 >> 18);
      m_a2 = s2 & ((64'd1 << 18) - 1);
      if (two) begin
         c3 = 0;
         m_a3 = 0;
      end else begin
         s3 = m_a3 + m_a2;
         c3 = int'(s3 >> 18);
         m_a3 = s3 & ((64'd1 << 18) - 1);
      end
      if (two) m_exp = c1 + c2 - m_c2d;
      else     m_exp = c1 + c2 - m_c2d + c3 - 2*m_c3d + m_c3dd;
      m_c2d  = c2;
      m_c3dd = two ? 0 : m_c3d;
      m_c3d  = c3;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: offset=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, update model, then compare after the edge
   task automatic cycle(input bit en, input logic [FRAC_W-1:0] k, input bit two,
                        input bit dth, input string req);
      @(negedge clk);
      step_en = en; frac_k = k; two_stage = two; dither_en = dth;
      if (en) model_step(longint'(k), two, dth);
      @(negedge clk);
      step_en = 1'b0;
      check(req, int'(offset), m_exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; step_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      @(negedge clk);
      check("R1", int'(offset), 0);
   endtask

   initial begin
      int sum;
      void'($urandom(32'h5a17c3));
      model_reset();
      do_reset();

      // R7: zero fraction, no dither, both orders
      for (int i = 0; i < 40; i++) cycle(1'b1, '0, i[0], 1'b0, "R7");

      // R2: hold without enable, then check nothing advanced
      cycle(1'b1, 18'h2aaaa, 1'b0, 1'b0, "R5");
      for (int i = 0; i < 8; i++) cycle(1'b0, 18'h3ffff, 1'b1, 1'b1, "R2");
      for (int i = 0; i < 6; i++) cycle(1'b1, 18'h2aaaa, 1'b0, 1'b0, "R2");

      // R9: output appears right after an enabled edge
      cycle(1'b1, 18'h3ffff, 1'b0, 1'b1, "R9");

      // R4 / R8: near-full fraction, two-stage, with and without dither
      for (int i = 0; i < 64; i++) cycle(1'b1, 18'h3ffff, 1'b1, i[1], "R4");
      // R5 / R6: three-stage with dither on small fraction
      for (int i = 0; i < 64; i++) cycle(1'b1, 18'h00001, 1'b0, 1'b1, "R6");

      // R10: order switch mid-run in both directions
      for (int i = 0; i < 48; i++) cycle(1'b1, 18'h1c3a5, (i / 12) % 2 == 1, 1'b0, "R10");

      // mean check on a quarter fraction, two-stage
      do_reset();
      sum = 0;
      for (int i = 0; i < 1024; i++) begin
         cycle(1'b1, 18'h10000, 1'b1, 1'b0, "R4");
         sum += int'(offset);
      end
      n_chk++;
      if (sum < 255 || sum > 257) begin
         n_bad++;
         $display("FAIL R4: mean sum=%0d expected=256", sum);
      end

      // constrained random mix
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         logic [FRAC_W-1:0] k;
         bit en, two, dth;
         k   = FRAC_W'($urandom);
         en  = ($urandom_range(0, 3) != 0);
         two = ($urandom_range(0, 15) < 8);
         dth = $urandom_range(0, 1) == 1;
         cycle(en, k, two, dth, "R3");
         n_chk++;
         if (int'(offset) < -3 || int'(offset) > 4) begin
            n_bad++;
            $display("FAIL R8: offset=%0d expected in -3..4", offset);
         end
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_T * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule